// File: doc/BRIEF.md
# PID Loop Filter with Filtered Derivative Lead

This block is the loop filter of a sampled phase-locked loop whose phase error has already passed through an averaging filter. It stands in for a plain proportional-integral filter so that the loop can run at a higher bandwidth. Each time a sample strobe arrives, with the loop sampled at 10 kHz, it takes one signed phase-error word. From that word it produces one signed frequency-correction word, and the output holds that word until the next strobe.

The filter is two sections in series. A proportional-integral section integrates the error with the trapezoidal rule. A first-order lead-lag section follows it, built from a derivative term with a pole that limits its high-frequency gain. The lead zero sits at half the averaging window, which offsets the lag of the averaging filter. The derivative pole sits at one tenth of that time constant. Both sections are the bilinear-transform images of the continuous design. All coefficients are worked out offline and enter as parameters in signed fixed point with `FRAC` fractional bits. Internal state is held in a wide signed format that clamps at its limits, and the output clamps to its own width.

A clear request empties the filter. It takes effect at the next sample strobe, or at once when it arrives together with a strobe. The sample presented at that strobe is discarded.

Top module: `pid_loop_filter`

## Requirements
- R1: While `rst_n` is low, `corr_out` is 0 and all filter state is zero.
- R2: `corr_out` changes only at a clock edge where `smp_stb` is high, and it shows the new result in the cycle after that edge. At every other edge it keeps its value.
- R3: At an accepted strobe with error e and previous error ep, the integrator becomes I = clamp(I + KIH·(e + ep)). The proportional-integral result is u = clamp(KP·e + I), using the new I. Coefficients are signed integers that stand for value·2^FRAC.
- R4: The lead-lag result is y = clamp((LB0·u + LB1·u_prev + LA1·y_prev) >>> FRAC), where >>> is an arithmetic shift that rounds toward minus infinity. The output is `corr_out` = clamp_out(y >>> FRAC). The values u_prev and y_prev are those of the previous accepted strobe.
- R5: clamp() limits I, u and y to the signed range of ACC_W bits. At that range they saturate and do not wrap.
- R6: clamp_out() limits `corr_out` to the signed range of OUT_W bits. It saturates at the extremes and does not wrap.
- R7: A strobe with `clr` high in the same cycle discards that sample. It zeroes the integrator, the stored error and both lead-lag states, and it sets `corr_out` to 0.
- R8: A `clr` pulse without a strobe leaves `corr_out` unchanged until the next strobe. That strobe then acts as in R7. Afterwards the filter answers exactly as it does after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | One-cycle strobe that marks a new error sample |
| clr | input | 1 | Request to empty the filter state at the next strobe |
| err_in | input | ERR_W | Signed phase-error sample |
| corr_out | output | OUT_W | Signed frequency correction, saturated |

## Verification
The collision that matters is a clear request meeting a sample strobe. It can happen in the same cycle, or a pending clear can be consumed by a later strobe. The bench provokes both cases: a clear pulse together with a strobe, and a clear pulse one cycle ahead of the strobe, each with a nonzero error and a loaded filter. A behavioural model runs on every clock and judges the result. The strobe must yield zero and discard its sample. The samples that follow must match the response from reset. Saturation of the integrator and of the output is provoked with a long run of full-scale error followed by a reversal. A wrapping state would show up in the recovery trajectory.

// File: rtl/pid_lf_pkg.sv
package pid_lf_pkg;
   localparam int WIDE_W = 64;
   typedef logic signed [WIDE_W-1:0] wide_t;

   // limit a value to the signed range of w bits
   function automatic wide_t clamp_s(input wide_t v, input int w);
      wide_t hi;
      wide_t lo;
      hi = (wide_t'(1) <<< (w - 1)) - wide_t'(1);
      lo = -hi - wide_t'(1);
      if (v > hi)      return hi;
      else if (v < lo) return lo;
      else             return v;
   endfunction
endpackage

// File: rtl/pid_pi_stage.sv
module pid_pi_stage
   import pid_lf_pkg::*;
#(
   parameter int ERR_W = 16,
   parameter int ACC_W = 40,
   parameter int KP    = 4096,
   parameter int KIH   = 18
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    stb,
   input  logic                    clr,
   input  logic signed [ERR_W-1:0] err,
   output logic signed [ACC_W-1:0] u
);
   localparam wide_t KP_W  = wide_t'(KP);
   localparam wide_t KIH_W = wide_t'(KIH);

   logic signed [ERR_W-1:0] e_prev;
   logic signed [ACC_W-1:0] integ;
   logic signed [ACC_W-1:0] integ_nx;

   always_comb begin
      integ_nx = ACC_W'(clamp_s(wide_t'(integ) +
                 KIH_W * (wide_t'(err) + wide_t'(e_prev)), ACC_W));
      u        = ACC_W'(clamp_s(KP_W * wide_t'(err) + wide_t'(integ_nx), ACC_W));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         integ  <= '0;
         e_prev <= '0;
      end else if (stb) begin
         if (clr) begin
            integ  <= '0;
            e_prev <= '0;
         end else begin
            integ  <= integ_nx;
            e_prev <= err;
         end
      end
   end

   // R3: integrator moves only on a strobe
   assert_pi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(integ) && $stable(e_prev));
   // R7: clear at a strobe empties the section
   assert_pi_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && clr) |=> (integ == '0) && (e_prev == '0));
endmodule

// File: rtl/pid_lead_stage.sv
module pid_lead_stage
   import pid_lf_pkg::*;
#(
   parameter int ACC_W = 40,
   parameter int FRAC  = 12,
   parameter int LB0   = 37609,
   parameter int LB1   = -36864,
   parameter int LA1   = 3351
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    stb,
   input  logic                    clr,
   input  logic signed [ACC_W-1:0] u,
   output logic signed [ACC_W-1:0] y
);
   localparam wide_t B0_W = wide_t'(LB0);
   localparam wide_t B1_W = wide_t'(LB1);
   localparam wide_t A1_W = wide_t'(LA1);

   logic signed [ACC_W-1:0] u_prev;
   logic signed [ACC_W-1:0] y_prev;

   always_comb begin
      y = ACC_W'(clamp_s((B0_W * wide_t'(u) + B1_W * wide_t'(u_prev) +
                          A1_W * wide_t'(y_prev)) >>> FRAC, ACC_W));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         u_prev <= '0;
         y_prev <= '0;
      end else if (stb) begin
         if (clr) begin
            u_prev <= '0;
            y_prev <= '0;
         end else begin
            u_prev <= u;
            y_prev <= y;
         end
      end
   end

   // R4: lead-lag history advances only on a strobe
   assert_ld_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(u_prev) && $stable(y_prev));
   // R7: clear at a strobe empties the history
   assert_ld_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && clr) |=> (u_prev == '0) && (y_prev == '0));
endmodule

// File: rtl/pid_loop_filter.sv
module pid_loop_filter
   import pid_lf_pkg::*;
#(
   parameter int ERR_W   = 16,
   parameter int OUT_W   = 16,
   parameter int COEF_W  = 18,
   parameter int FRAC    = 12,
   parameter int ACC_W   = 40,
   parameter bit LEAD_EN = 1'b1,
   parameter int KP      = 4096,
   parameter int KIH     = 18,
   parameter int LB0     = 37609,
   parameter int LB1     = -36864,
   parameter int LA1     = 3351
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_stb,
   input  logic                    clr,
   input  logic signed [ERR_W-1:0] err_in,
   output logic signed [OUT_W-1:0] corr_out
);
   localparam int COEF_MAX = (1 << (COEF_W - 1)) - 1;

   initial begin
      assert_param_width: assert (ACC_W + COEF_W + 4 <= WIDE_W && ERR_W < ACC_W
                                  && OUT_W <= ACC_W && FRAC < ACC_W && COEF_W < 31);
      assert_param_coef: assert (KP <= COEF_MAX && KP >= -COEF_MAX - 1 &&
                                 KIH <= COEF_MAX && KIH >= -COEF_MAX - 1 &&
                                 LB0 <= COEF_MAX && LB0 >= -COEF_MAX - 1 &&
                                 LB1 <= COEF_MAX && LB1 >= -COEF_MAX - 1 &&
                                 LA1 <= COEF_MAX && LA1 >= -COEF_MAX - 1);
   end

   logic                    clr_pend;
   logic                    clr_now;
   logic signed [ACC_W-1:0] u;
   logic signed [ACC_W-1:0] y;
   logic signed [OUT_W-1:0] out_nx;

   assign clr_now = clr | clr_pend;

   pid_pi_stage #(.ERR_W(ERR_W), .ACC_W(ACC_W), .KP(KP), .KIH(KIH)) u_pi (
      .clk(clk), .rst_n(rst_n), .stb(smp_stb), .clr(clr_now),
      .err(err_in), .u(u));

   generate
      if (LEAD_EN) begin : g_lead
         pid_lead_stage #(.ACC_W(ACC_W), .FRAC(FRAC), .LB0(LB0), .LB1(LB1),
                          .LA1(LA1)) u_lead (
            .clk(clk), .rst_n(rst_n), .stb(smp_stb), .clr(clr_now),
            .u(u), .y(y));
      end else begin : g_pi_only
         assign y = u;
      end
   endgenerate

   assign out_nx = OUT_W'(clamp_s(wide_t'(y) >>> FRAC, OUT_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_pend <= 1'b0;
         corr_out <= '0;
      end else begin
         clr_pend <= smp_stb ? 1'b0 : (clr_pend | clr);
         if (smp_stb) corr_out <= clr_now ? '0 : out_nx;
      end
   end

   // R2: output holds between strobes
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> $stable(corr_out));
   // R7: clear together with a strobe yields zero
   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && clr) |=> corr_out == '0);
   // R8: a clear pulse followed by a strobe yields zero
   assert_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !smp_stb) ##1 smp_stb |=> corr_out == '0);
endmodule

// File: tb/sim_pid_loop_filter.sv
module sim_pid_loop_filter;
   localparam int ERR_W = 16;
   localparam int OUT_W = 16;
   localparam int FRAC  = 12;
   localparam int ACC_W = 32;
   localparam int KP    = 4096;
   localparam int KIH   = 18;
   localparam int LB0   = 37609;
   localparam int LB1   = -36864;
   localparam int LA1   = 3351;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_stb = 1'b0;
   logic clr = 1'b0;
   logic signed [ERR_W-1:0] err_in = '0;
   logic signed [OUT_W-1:0] corr_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit run = 1'b0;
   string tag = "R1";

   always #5 clk = ~clk;

   pid_loop_filter #(.ERR_W(ERR_W), .OUT_W(OUT_W), .FRAC(FRAC), .ACC_W(ACC_W),
                     .KP(KP), .KIH(KIH), .LB0(LB0), .LB1(LB1), .LA1(LA1)) u0 (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .clr(clr),
      .err_in(err_in), .corr_out(corr_out));

   // behavioural reference
   longint m_i, m_ep, m_up, m_yp, m_out;
   bit m_pend;

   function automatic longint sat(input longint v, input int w);
      longint hi;
      hi = (longint'(1) <<< (w - 1)) - 1;
      if (v > hi) return hi;
      if (v < -hi - 1) return -hi - 1;
      return v;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      longint e, u, y;
      if (!rst_n) begin
         m_i = 0; m_ep = 0; m_up = 0; m_yp = 0; m_out = 0; m_pend = 0;
      end else if (smp_stb) begin
         if (clr || m_pend) begin
            m_i = 0; m_ep = 0; m_up = 0; m_yp = 0; m_out = 0;
         end else begin
            e = longint'(err_in);
            m_i = sat(m_i + KIH * (e + m_ep), ACC_W);
            u = sat(KP * e + m_i, ACC_W);
            y = sat((LB0 * u + LB1 * m_up + LA1 * m_yp) >>> FRAC, ACC_W);
            m_out = sat(y >>> FRAC, OUT_W);
            m_ep = e; m_up = u; m_yp = y;
         end
         m_pend = 0;
      end else if (clr) begin
         m_pend = 1;
      end
   end

   task automatic chk(input string t, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", t, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (run) chk(tag, longint'(corr_out), m_out);

   task automatic sample(input int e, input bit c);
      @(negedge clk);
      err_in = ERR_W'(e); smp_stb = 1'b1; clr = c;
      @(negedge clk);
      smp_stb = 1'b0; clr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      longint held;
      idle(3);
      chk("R1 reset output", longint'(corr_out), 0);
      rst_n = 1'b1;
      run = 1'b1;
      idle(2);
      chk("R1 after release", longint'(corr_out), 0);

      // R3 R4: first sample after reset, hand-computed value 922
      tag = "R3 R4 first sample";
      sample(100, 0);
      chk("R4 first sample value", longint'(corr_out), 922);

      // R2: slow strobes with holding in between
      tag = "R2 spaced strobes";
      for (int k = 0; k < 20; k++) begin
         sample((k * 37) % 200 - 100, 0);
         held = longint'(corr_out);
         idle(8);
         chk("R2 hold between strobes", longint'(corr_out), held);
      end

      // R3 R4: back-to-back strobes, varied pattern
      tag = "R3 R4 random pattern";
      for (int k = 0; k < 300; k++) sample(int'($urandom_range(0, 400)) - 200, 0);
      tag = "R3 R4 step";
      for (int k = 0; k < 200; k++) sample(50, 0);

      // R7: clear with strobe, loaded filter
      tag = "R7 clear with strobe";
      sample(1000, 1);
      chk("R7 clear output zero", longint'(corr_out), 0);
      sample(100, 0);
      chk("R7 restart like reset", longint'(corr_out), 922);

      // R8: clear between strobes
      tag = "R8 pending clear";
      for (int k = 0; k < 30; k++) sample(40, 0);
      held = longint'(corr_out);
      @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
      idle(4);
      chk("R8 output unchanged before strobe", longint'(corr_out), held);
      sample(777, 0);
      chk("R8 pending clear output zero", longint'(corr_out), 0);
      sample(100, 0);
      chk("R8 restart like reset", longint'(corr_out), 922);

      // R8: clear pulse immediately followed by a strobe
      for (int k = 0; k < 10; k++) sample(-60, 0);
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0; err_in = 16'sd500; smp_stb = 1'b1;
      @(negedge clk); smp_stb = 1'b0;
      chk("R8 adjacent clear output zero", longint'(corr_out), 0);

      // R5 R6: drive integrator into saturation, then reverse
      tag = "R5 R6 saturation";
      for (int k = 0; k < 2500; k++) sample(32767, 0);
      chk("R6 output at positive limit", longint'(corr_out), 32767);
      for (int k = 0; k < 2500; k++) sample(-32768, 0);
      chk("R6 output at negative limit", longint'(corr_out), -32768);
      tag = "R5 recovery";
      for (int k = 0; k < 400; k++) sample(200, 0);

      // R1: reset in mid-run
      run = 1'b0;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset mid-run", longint'(corr_out), 0);
      rst_n = 1'b1;
      run = 1'b1;
      tag = "R1 after second reset";
      sample(100, 0);
      chk("R1 response after reset", longint'(corr_out), 922);

      idle(2);
      run = 1'b0;
      done = 1'b1;
      finish_run();
   end
endmodule